// File: doc/BRIEF.md
# One-Second Reference Tick Generator

This block turns a global 8 kHz reference into a one-second timing reference inside a fast system-clock domain. The 8 kHz input is asynchronous to the system clock. It passes through a two-stage synchroniser, and a registered copy of the synchronised signal yields a single-cycle rising-edge strobe. A divider counts these strobes. It toggles an output level after each half of the division ratio, so the output is a square wave whose period is the full ratio of reference edges (8000 by default).

Each low-to-high transition of the one-second level produces three effects. It sets a sticky status bit, which holds until software clears it. That status bit drives an interrupt line, gated by an enable bit. When the upper bit of a two-bit update-mode field is set, the transition also emits a one-cycle pulse that requests a performance-monitor update. Choosing which 8 kHz source feeds the block is left to the surrounding logic.

Top module: `onesec_ref_gen`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `sec_level`, `sec_stat`, `sec_irq` and `pm_upd` are all 0, and the internal edge count is zero.
- R2: Counting synchronised rising edges of `ref8k_in` from reset as k = 1, 2, ..., `sec_level` is high when (k / (DIV_RATIO/2)) is odd and low otherwise. The output is therefore low for the first DIV_RATIO/2 edges and high for the next DIV_RATIO/2, with a period of DIV_RATIO edges.
- R3: Only rising edges of the synchronised reference advance the count. Holding `ref8k_in` high or low for any number of cycles counts as nothing beyond the single rising edge.
- R4: If a rising edge of `ref8k_in` is applied before clock edge 1, its effect on `sec_level`, `sec_stat` and `pm_upd` appears at clock edge 3 and not before.
- R5: A low-to-high transition of `sec_level` sets `sec_stat` on the same clock edge. `sec_stat` then stays set while `stat_clr` is low.
- R6: `stat_clr` high for one cycle with no coinciding `sec_level` rise clears `sec_stat` on that edge.
- R7: When a `sec_level` rise and `stat_clr` fall on the same clock edge, `sec_stat` stays 1.
- R8: `sec_irq` equals `sec_stat AND irq_en` at all times.
- R9: When `upd_mode[1]` is 1, every `sec_level` rise produces exactly one `pm_upd` pulse, one system-clock cycle long, on the same edge. `upd_mode[0]` has no effect.
- R10: When `upd_mode[1]` is 0, `pm_upd` stays 0, including across `sec_level` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref8k_in | input | 1 | Global 8 kHz reference, asynchronous to clk |
| stat_clr | input | 1 | One-cycle strobe that clears the sticky status bit |
| irq_en | input | 1 | Interrupt enable for the status bit |
| upd_mode | input | 2 | Update-mode field; bit 1 high enables update pulses |
| sec_level | output | 1 | One-second square-wave level |
| sec_stat | output | 1 | Sticky one-second status bit |
| sec_irq | output | 1 | Interrupt request, the status bit gated by the enable |
| pm_upd | output | 1 | One-cycle performance-monitor update request |

## Verification
The sticky status bit is driven by two things: the set that comes from a one-second rise and the clear strobe from software. These two can land on the same clock edge. The bench counts reference edges so that it knows which edge will complete the low half-period. It then raises `stat_clr` in exactly the cycle in which the synchronised rising edge is being registered. It judges the result by reading `sec_stat` at the next falling clock edge and expecting 1. The bench also checks separately that a clear with no such coincidence does drop the bit.

// File: rtl/onesec_pkg.sv
// Package: shared types and helpers for the one-second reference generator.
// Assumes: the update-mode field is two bits and only its upper bit enables updates.
package onesec_pkg;

    typedef logic [1:0] upd_mode_t;

    // Returns 1 when the mode field asks for performance-monitor updates on each tick.
    function automatic logic upd_wanted(input upd_mode_t mode);
        return mode[1];
    endfunction

endpackage

// File: rtl/onesec_sync.sv
// Module: multi-stage synchroniser for a single asynchronous input bit.
// Assumes: STAGES >= 2; the input is a slow level signal, so no pulse is shorter than a clock.
module onesec_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous bit through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/onesec_edge.sv
// Module: rising-edge detector on an already synchronised level.
// Assumes: the input is synchronous to clk; the output is a one-cycle strobe.
module onesec_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);

    logic level_q;

    // Keep the previous cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_in;
        end
    end

    assign rise = level_in & ~level_q;

endmodule

// File: rtl/onesec_div.sv
// Module: edge-counting divider that builds a square wave, toggling every DIV_RATIO/2 edges.
// Assumes: DIV_RATIO is even and at least 4; edge_stb is a one-cycle strobe.
module onesec_div #(
    parameter int DIV_RATIO = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_stb,
    output logic level,
    output logic tick_up
);

    localparam int HALF = DIV_RATIO / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap    = edge_stb && (cnt_q == LAST);
    assign tick_up = wrap && !level;

    // Count edges within a half period and toggle the level at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            level <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            level <= ~level;
        end else if (edge_stb) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/onesec_evt.sv
// Module: reacts to the one-second rise: sticky status, gated interrupt, update pulse.
// Assumes: tick is a one-cycle strobe marking the cycle before the level goes high.
module onesec_evt
    import onesec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      stat_clr,
    input  logic      irq_en,
    input  upd_mode_t upd_mode,
    output logic      sec_stat,
    output logic      sec_irq,
    output logic      pm_upd
);

    // Sticky bit: a set wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_stat <= 1'b0;
        end else begin
            sec_stat <= tick | (sec_stat & ~stat_clr);
        end
    end

    // One-cycle update request, aligned with the level rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_upd <= 1'b0;
        end else begin
            pm_upd <= tick & upd_wanted(upd_mode);
        end
    end

    // Interrupt follows the sticky bit while enabled.
    always_comb begin
        sec_irq = sec_stat & irq_en;
    end

endmodule

// File: rtl/onesec_ref_gen.sv
// Module: top of the one-second reference generator.
// Assumes: ref8k_in is asynchronous and far slower than clk; reset is synchronous, active low.
module onesec_ref_gen
    import onesec_pkg::*;
#(
    parameter int DIV_RATIO   = 8000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref8k_in,
    input  logic       stat_clr,
    input  logic       irq_en,
    input  logic [1:0] upd_mode,
    output logic       sec_level,
    output logic       sec_stat,
    output logic       sec_irq,
    output logic       pm_upd
);

    logic ref_sync;
    logic edge_rise;
    logic tick_up;

    onesec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ref8k_in),
        .sync_out (ref_sync)
    );

    onesec_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (ref_sync),
        .rise     (edge_rise)
    );

    onesec_div #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_stb (edge_rise),
        .level    (sec_level),
        .tick_up  (tick_up)
    );

    onesec_evt u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_up),
        .stat_clr (stat_clr),
        .irq_en   (irq_en),
        .upd_mode (upd_mode_t'(upd_mode)),
        .sec_stat (sec_stat),
        .sec_irq  (sec_irq),
        .pm_upd   (pm_upd)
    );

endmodule

// File: rtl/onesec_ref_chk.sv
// Module: property checker for the one-second reference generator, bound to the top.
// Assumes: edge_rise is the top's synchronised edge strobe.
module onesec_ref_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       edge_rise,
    input logic       stat_clr,
    input logic       irq_en,
    input logic [1:0] upd_mode,
    input logic       sec_level,
    input logic       sec_stat,
    input logic       sec_irq,
    input logic       pm_upd
);

    // R3
    level_moves_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sec_level) |-> $past(edge_rise));

    // R5
    stat_set_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_level) |-> sec_stat);

    // R5
    stat_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_stat && !stat_clr |=> sec_stat);

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !sec_irq);

    // R8
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_stat && irq_en |-> sec_irq);

    // R9
    pm_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_upd |=> !pm_upd);

    // R9
    pm_with_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_upd |-> $rose(sec_level));

    // R10
    pm_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_upd |-> $past(upd_mode[1]));

endmodule

bind onesec_ref_gen onesec_ref_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_rise (edge_rise),
    .stat_clr  (stat_clr),
    .irq_en    (irq_en),
    .upd_mode  (upd_mode),
    .sec_level (sec_level),
    .sec_stat  (sec_stat),
    .sec_irq   (sec_irq),
    .pm_upd    (pm_upd)
);

// File: tb/tb_onesec_ref_gen.sv
module tb_onesec_ref_gen;

    localparam int DIV  = 8;
    localparam int HALF = DIV / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref8k_in = 1'b0;
    logic       stat_clr = 1'b0;
    logic       irq_en = 1'b0;
    logic [1:0] upd_mode = 2'b00;
    logic       sec_level, sec_stat, sec_irq, pm_upd;

    int checks = 0;
    int errors = 0;
    int k = 0;          // rising edges applied since reset
    int pm_cnt = 0;     // pulses seen by the monitor
    bit exp_stat = 1'b0;

    always #10 clk = ~clk;

    onesec_ref_gen #(.DIV_RATIO(DIV), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .ref8k_in(ref8k_in), .stat_clr(stat_clr),
        .irq_en(irq_en), .upd_mode(upd_mode), .sec_level(sec_level),
        .sec_stat(sec_stat), .sec_irq(sec_irq), .pm_upd(pm_upd)
    );

    // count update pulses, one per sampled high cycle
    always @(negedge clk) if (rst_n && pm_upd) pm_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit lvl_of(input int n);
        return ((n / HALF) % 2) == 1;
    endfunction

    // one reference edge; clr_at_tick raises stat_clr on the registering edge
    task automatic ref_pulse(input bit clr_at_tick, input int hi_cycles);
        bit old_lvl, new_lvl, rise_now;
        int pm_before;
        pm_before = pm_cnt;
        old_lvl = lvl_of(k);
        new_lvl = lvl_of(k + 1);
        rise_now = new_lvl && !old_lvl;
        @(negedge clk) ref8k_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // after two edges nothing has moved yet
        if (new_lvl != old_lvl)
            chk(sec_level == old_lvl, "R4", sec_level, old_lvl);
        stat_clr = clr_at_tick;
        @(negedge clk);
        stat_clr = 1'b0;
        k++;
        if (rise_now) exp_stat = 1'b1;
        else if (clr_at_tick) exp_stat = 1'b0;
        chk(sec_level == new_lvl, "R2", sec_level, new_lvl);
        chk(sec_stat == exp_stat, clr_at_tick && rise_now ? "R7" : "R5", sec_stat, exp_stat);
        chk(sec_irq == (exp_stat && irq_en), "R8", sec_irq, exp_stat && irq_en);
        for (int i = 3; i < hi_cycles; i++) begin
            @(negedge clk);
            chk(sec_level == new_lvl, "R3", sec_level, new_lvl);
        end
        ref8k_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(pm_cnt - pm_before == ((rise_now && upd_mode[1]) ? 1 : 0),
            upd_mode[1] ? "R9" : "R10", pm_cnt - pm_before,
            (rise_now && upd_mode[1]) ? 1 : 0);
    endtask

    task automatic do_clear();
        @(negedge clk) stat_clr = 1'b1;
        @(negedge clk) stat_clr = 1'b0;
        exp_stat = 1'b0;
        chk(sec_stat == 1'b0, "R6", sec_stat, 0);
        chk(sec_irq == 1'b0, "R8", sec_irq, 0);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(sec_level == 1'b0, "R1", sec_level, 0);
        chk(sec_stat == 1'b0, "R1", sec_stat, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sec_level == 1'b0, "R1", sec_level, 0);
        chk(sec_stat == 1'b0, "R1", sec_stat, 0);
        chk(sec_irq == 1'b0, "R1", sec_irq, 0);
        chk(pm_upd == 1'b0, "R1", pm_upd, 0);

        // full sweep over every edge position, updates and interrupt enabled
        upd_mode = 2'b10;
        irq_en = 1'b1;
        for (int e = 0; e < 2 * DIV; e++) ref_pulse(1'b0, 3);

        // long held levels still count once per rising edge (R3)
        for (int e = 0; e < DIV; e++) ref_pulse(1'b0, 40);

        // every mode and enable combination over a whole period (R9, R10, R8)
        for (int m = 0; m < 4; m++) begin
            for (int en = 0; en < 2; en++) begin
                upd_mode = 2'(m);
                irq_en = en[0];
                @(negedge clk);
                chk(sec_irq == (exp_stat && irq_en), "R8", sec_irq, exp_stat && irq_en);
                for (int e = 0; e < DIV; e++) ref_pulse(1'b0, 3);
                do_clear();
            end
        end

        // clear mid-period, then clear coinciding with the rise (R6, R7)
        upd_mode = 2'b11;
        irq_en = 1'b1;
        for (int rep = 0; rep < 3; rep++) begin
            while (((k + 1) % DIV) != HALF) ref_pulse(1'b0, 3);
            do_clear();
            ref_pulse(1'b1, 3);
            chk(sec_stat == 1'b1, "R7", sec_stat, 1);
            ref_pulse(1'b1, 3);
            chk(sec_stat == 1'b0, "R6", sec_stat, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule